// File: doc/BRIEF.md
# Iterative Logical Right Shifter

This unit executes a logical right shift of one register-file word by an amount carried in a small instruction field, moving the value a single bit position per pass. It captures the operand, the register index and the amount when a start strobe arrives while idle. The amount is widened with leading zeros into a private down-counter. A zero amount finishes at once without touching the register file.

Each pass presents the word shifted one more place to the right on the write-back port, aimed at the same register it came from, so the register file holds the partial result after every pass. The counter drops by one each pass, and a test step between passes decides whether to loop again or finish. The sequencing uses three working states, a load-and-test step, a shift-and-count step and a counter test step, plus an idle state.

Top module: `iter_rshift`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o and wb_we_o are all 0.
- R2: A start_i sampled high at a rising edge while busy_o is 0 captures amt_i, opnd_i and reg_idx_i, and busy_o is 1 in the cycle after that edge.
- R3: When the captured amount is 0, done_o is 1 in the first cycle after the start edge, wb_we_o never rises, and busy_o is 0 in the cycle after.
- R4: For a captured amount n > 0, the k-th write-back (k = 1..n) appears in the cycle that begins 2k-1 rising edges after the start edge, with wb_we_o = 1 and wb_data_o equal to the operand shifted right by k places.
- R5: The shift is logical: a 0 enters bit 31 (the most significant bit) on every pass, so wb_data_o bit 31 is 0 whenever wb_we_o is 1.
- R6: wb_idx_o equals the captured register index on every write-back; source and destination are the same register.
- R7: Exactly n write-backs occur for amount n, never two in consecutive cycles, and the last one carries the operand shifted right by n.
- R8: For n > 0, done_o is 1 for exactly one cycle, the one beginning 2n rising edges after the start edge; busy_o stays 1 from the cycle after the start edge through that cycle and is 0 in the next.
- R9: A start_i that arrives while busy_o is 1 is ignored: the write-back sequence, index and done timing of the running operation are unchanged.
- R10: The largest amount, 31, is handled: 31 write-backs and a final value equal to the operand shifted right by 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, honoured only when idle |
| amt_i | input | 5 | Shift amount field |
| opnd_i | input | 32 | Operand word read from the register file |
| reg_idx_i | input | 5 | Register index of the operand |
| wb_data_o | output | 32 | Write-back word, operand shifted one more place per pass |
| wb_idx_o | output | 5 | Write-back register index (same as source) |
| wb_we_o | output | 1 | Register write enable, one cycle per pass |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, a 5-bit amount field, a 32-bit counter and a 5-bit register index. With these the whole amount range 0 to 31 is reachable, including the immediate-exit case at 0 and the longest loop of 31 passes and 63 busy cycles, so the counter's zero test is exercised at both ends. Operands with the top bit set show the zero fill into the most significant bit, and strobes injected in the load, shift and test states show that the captured amount, operand and index cannot be disturbed mid-run.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

  // Sequencer states: idle, load-and-test, shift-and-count, counter test.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_STEP = 2'd2,
    ST_TEST = 2'd3
  } rsh_state_e;

endpackage

// File: rtl/rsh_rst_sync.sv
module rsh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;

  // Assertion is immediate, release is aligned to the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/rsh_ctrl.sv
module rsh_ctrl
  import rshift_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       cnt_zero_i,
  output rsh_state_e state_o,
  output logic       load_en_o,
  output logic       step_en_o,
  output logic       busy_o,
  output logic       done_o
);

  rsh_state_e state_q;
  rsh_state_e state_d;
  logic       finish;

  // Next-state process.
  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        // Zero amount: leave without a single pass.
        if (cnt_zero_i) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_STEP;
        end
      end
      ST_STEP: begin
        state_d = ST_TEST;
      end
      ST_TEST: begin
        if (cnt_zero_i) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_STEP;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign load_en_o = (state_q == ST_IDLE) && start_i;
  assign step_en_o = (state_q == ST_STEP);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = finish;

endmodule

// File: rtl/rsh_counter.sv
module rsh_counter #(
  parameter int AMT_W = 5,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en_i,
  input  logic             step_en_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic             zero_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] amt_ext;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Zero-fill the amount field up to the counter width.
  generate
    if (CNT_W > AMT_W) begin : g_pad
      assign amt_ext = {{(CNT_W-AMT_W){1'b0}}, amt_i};
    end else begin : g_nopad
      assign amt_ext = amt_i[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    cnt_en = load_en_i | step_en_i;
    cnt_d  = cnt_q;
    if (load_en_i) begin
      cnt_d = amt_ext;
    end else if (step_en_i) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rsh_datapath.sv
module rsh_datapath #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en_i,
  input  logic              step_en_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [IDX_W-1:0]  wb_idx_o
);

  logic [DATA_W-1:0] work_q;
  logic [DATA_W-1:0] work_d;
  logic [DATA_W-1:0] shifted;
  logic [IDX_W-1:0]  idx_q;
  logic              work_en;

  // One logical position per pass: zero into the top bit.
  assign shifted = {1'b0, work_q[DATA_W-1:1]};

  always_comb begin
    work_en = load_en_i | step_en_i;
    work_d  = work_q;
    if (load_en_i) begin
      work_d = opnd_i;
    end else if (step_en_i) begin
      work_d = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_en_i) begin
      idx_q <= idx_i;
    end
  end

  assign wb_data_o = shifted;
  assign wb_idx_o  = idx_q;

endmodule

// File: rtl/iter_rshift.sv
module iter_rshift
  import rshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 5,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic              wb_we_o,
  output logic              busy_o,
  output logic              done_o
);

  rsh_state_e state;
  logic       rst_n_int;
  logic       load_en;
  logic       step_en;
  logic       cnt_zero;

  rsh_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  rsh_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (start_i),
    .cnt_zero_i (cnt_zero),
    .state_o    (state),
    .load_en_o  (load_en),
    .step_en_o  (step_en),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  rsh_counter #(.AMT_W(AMT_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_en_i (load_en),
    .step_en_i (step_en),
    .amt_i     (amt_i),
    .zero_o    (cnt_zero)
  );

  rsh_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_en_i (load_en),
    .step_en_i (step_en),
    .opnd_i    (opnd_i),
    .idx_i     (reg_idx_i),
    .wb_data_o (wb_data_o),
    .wb_idx_o  (wb_idx_o)
  );

  assign wb_we_o = step_en;

endmodule

// File: rtl/iter_rshift_chk.sv
module iter_rshift_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] wb_data_o,
  input logic [IDX_W-1:0]  wb_idx_o,
  input logic              wb_we_o,
  input logic              busy_o,
  input logic              done_o
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy_o && !done_o && !wb_we_o));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> (wb_data_o[DATA_W-1] == 1'b0));

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(wb_idx_o));

  // R7
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |=> !wb_we_o);

  // R7
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> busy_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R8
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && !wb_we_o));

endmodule

bind iter_rshift iter_rshift_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .wb_data_o (wb_data_o),
  .wb_idx_o  (wb_idx_o),
  .wb_we_o   (wb_we_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/iter_rshift_tb.sv
`timescale 1ns/1ps
module iter_rshift_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  amt_i;
  logic [31:0] opnd_i;
  logic [4:0]  reg_idx_i;
  logic [31:0] wb_data_o;
  logic [4:0]  wb_idx_o;
  logic        wb_we_o;
  logic        busy_o;
  logic        done_o;

  int checks;
  int failures;
  int cycles;

  iter_rshift u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .amt_i     (amt_i),
    .opnd_i    (opnd_i),
    .reg_idx_i (reg_idx_i),
    .wb_data_o (wb_data_o),
    .wb_idx_o  (wb_idx_o),
    .wb_we_o   (wb_we_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one operation. glitch_at >= 0 raises start_i with junk in that cycle.
  task automatic run_op(input logic [31:0] opnd, input int n, input logic [4:0] idx,
                        input int glitch_at);
    int writes;
    logic [31:0] last;
    writes = 0;
    last   = opnd;
    @(negedge clk);
    start_i   = 1'b1;
    amt_i     = n[4:0];
    opnd_i    = opnd;
    reg_idx_i = idx;
    @(negedge clk);
    start_i   = 1'b0;
    amt_i     = 5'h1f ^ n[4:0];
    opnd_i    = ~opnd;
    reg_idx_i = ~idx;
    // R2: busy right after the start edge
    check("R2", "busy after start", {31'd0, busy_o}, 32'd1);
    for (int c = 0; c <= 2 * n; c++) begin
      if (c > 0) @(negedge clk);
      start_i = 1'b0;
      check("R8", "busy held", {31'd0, busy_o}, 32'd1);
      check((n == 0) ? "R3" : "R8", "done timing", {31'd0, done_o},
            {31'd0, (c == 2 * n)});
      check("R4", "write enable timing", {31'd0, wb_we_o}, {31'd0, (c % 2 == 1)});
      if (wb_we_o) begin
        writes++;
        last = wb_data_o;
        check("R4", "write data", wb_data_o, opnd >> ((c + 1) / 2));
        check("R5", "zero fill msb", {31'd0, wb_data_o[31]}, 32'd0);
        check("R6", "write index", {27'd0, wb_idx_o}, {27'd0, idx});
      end
      if (c == glitch_at) begin
        start_i   = 1'b1;
        amt_i     = 5'd3;
        opnd_i    = 32'hffff_ffff;
        reg_idx_i = idx + 5'd1;
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    check((n == 0) ? "R3" : "R8", "idle after done", {31'd0, busy_o}, 32'd0);
    check("R8", "done dropped", {31'd0, done_o}, 32'd0);
    check("R7", "write count", writes, n);
    if (n > 0) check("R7", "final value", last, opnd >> n);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start_i = 1'b0; amt_i = '0; opnd_i = '0; reg_idx_i = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1", "done in reset", {31'd0, done_o}, 32'd0);
    check("R1", "we in reset", {31'd0, wb_we_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "busy after release", {31'd0, busy_o}, 32'd0);
    check("R1", "we after release", {31'd0, wb_we_o}, 32'd0);
  endtask

  task automatic t_zero_amount();
    run_op(32'hdead_beef, 0, 5'd7, -1);   // R3
  endtask

  task automatic t_single();
    run_op(32'h8000_0001, 1, 5'd2, -1);   // R4 R5
  endtask

  task automatic t_typical();
    run_op(32'hf0f0_a5a5, 5, 5'd19, -1);  // R4 R6 R7
    run_op(32'h1234_5678, 12, 5'd0, -1);
  endtask

  task automatic t_max();
    run_op(32'hffff_ffff, 31, 5'd31, -1); // R10
  endtask

  task automatic t_ignore_start();
    run_op(32'hcafe_f00d, 4, 5'd9, 0);    // R9 in load state
    run_op(32'h8765_4321, 4, 5'd10, 1);   // R9 in shift state
    run_op(32'h0bad_c0de, 3, 5'd11, 2);   // R9 in test state
    run_op(32'h5555_aaaa, 0, 5'd12, 0);   // R9 during immediate exit
  endtask

  initial begin
    checks = 0;
    failures = 0;
    t_reset();
    t_zero_amount();
    t_single();
    t_typical();
    t_max();
    t_ignore_start();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule